// File: doc/BRIEF.md
# Transport Stream Output Bypass Multiplexer

This block sits in front of a parallel transport-stream output port. The port has eight data lines, a byte clock, a packet-start line, a data-valid line and an error line. In its normal setting the block hands the decoder's packet stream to the port unchanged. When a two-bit route selector holds the bypass code, the block instead places the low byte of a 10-bit video converter sample on the data lines and the converter clock on the clock line. In that setting the packet-start and valid lines are held low, and the error line sits at a level chosen by a polarity control.

A separate enable input decides whether the port drives at all. The three-state behaviour is modelled as one output-enable bit per pin, so the pad ring can build the actual tristate buffers. The path is purely combinational. The converter clock therefore reaches the output pin without passing through any register.

Top module: `ts_out_bypass_mux`

## Requirements
- R1: When `modeSel` is 2'b00, 2'b01 or 2'b11, `outData` equals `tsData` in the same cycle.
- R2: When `modeSel` is not 2'b10, `outClk`, `outSync`, `outValid` and `outErr` equal `tsClk`, `tsSync`, `tsValid` and `tsErr`, and `errPolarity` has no effect on them.
- R3: When `modeSel` is 2'b10, `outData` equals `adcData[7:0]`, and `adcData[9:8]` has no effect on any output.
- R4: When `modeSel` is 2'b10, `outClk` equals `adcClk`.
- R5: When `modeSel` is 2'b10, `outSync` and `outValid` are 0 whatever the decoder drives.
- R6: When `modeSel` is 2'b10, `outErr` equals `errPolarity`, and `tsErr` is ignored.
- R7: `outOe` is all zeros when `outEnable` is 0 and all ones when it is 1. Bit layout: [7:0] data lines, [8] clock, [9] sync, [10] valid, [11] error.
- R8: `outEnable` changes only `outOe`. The levels on `outData`, `outClk`, `outSync`, `outValid` and `outErr` are the same with the enable at 0 or at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| modeSel | input | 2 | Route selector; 2'b10 selects video bypass |
| errPolarity | input | 1 | Error-line level used in bypass |
| outEnable | input | 1 | 1 drives the port, 0 floats every pin |
| tsData | input | 8 | Decoder packet byte |
| tsClk | input | 1 | Decoder byte clock |
| tsSync | input | 1 | Decoder packet-start flag |
| tsValid | input | 1 | Decoder data-valid flag |
| tsErr | input | 1 | Decoder packet-error flag |
| adcData | input | 10 | Converter sample |
| adcClk | input | 1 | Converter sample clock |
| outData | output | 8 | Port data lines |
| outClk | output | 1 | Port clock line |
| outSync | output | 1 | Port packet-start line |
| outValid | output | 1 | Port valid line |
| outErr | output | 1 | Port error line |
| outOe | output | 12 | Per-pin drive enable |

## Verification
The assertions are evaluated whenever any input changes. They cover the route chosen for every output line in both settings, the forced-low framing lines, the error level in bypass and the all-or-nothing enable vector. The bench alone can show that an input has no effect. Examples are the upper converter bits, the decoder error flag in bypass, and the enable's lack of influence on pin levels. It does this by sweeping every mode, polarity and enable combination over varied data and sideband patterns, and comparing each pin against values it computes itself.

// File: rtl/ts_out_bypass_pkg.sv
package ts_out_bypass_pkg;

  localparam logic [1:0] MODE_BYPASS = 2'b10;

  typedef struct packed {
    logic selBypass;
    logic drive;
    logic errLevel;
  } routeStrobes_t;

endpackage

// File: rtl/ts_out_bypass_ctrl.sv
module ts_out_bypass_ctrl
  import ts_out_bypass_pkg::*;
(
  input  logic [1:0]    modeSel,
  input  logic          errPolarity,
  input  logic          outEnable,
  output routeStrobes_t strb
);

  always_comb begin
    strb.selBypass = (modeSel == MODE_BYPASS);
    strb.drive     = outEnable;
    strb.errLevel  = errPolarity;
  end

endmodule

// File: rtl/ts_out_bypass_path.sv
module ts_out_bypass_path
  import ts_out_bypass_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PIN_N = DATA_W + 4
) (
  input  routeStrobes_t     strb,
  input  logic [DATA_W-1:0] tsData,
  input  logic              tsClk,
  input  logic              tsSync,
  input  logic              tsValid,
  input  logic              tsErr,
  input  logic [DATA_W-1:0] adcLow,
  input  logic              adcClk,
  output logic [DATA_W-1:0] outData,
  output logic              outClk,
  output logic              outSync,
  output logic              outValid,
  output logic              outErr,
  output logic [PIN_N-1:0]  outOe
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_dataBit
    assign outData[b] = strb.selBypass ? adcLow[b] : tsData[b];
  end

  assign outClk   = strb.selBypass ? adcClk        : tsClk;
  assign outSync  = strb.selBypass ? 1'b0          : tsSync;
  assign outValid = strb.selBypass ? 1'b0          : tsValid;
  assign outErr   = strb.selBypass ? strb.errLevel : tsErr;

  for (genvar p = 0; p < PIN_N; p++) begin : g_pinOe
    assign outOe[p] = strb.drive;
  end

endmodule

// File: rtl/ts_out_bypass_mux.sv
module ts_out_bypass_mux
  import ts_out_bypass_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADC_W  = 10,
  localparam int PIN_N = DATA_W + 4
) (
  input  logic [1:0]        modeSel,
  input  logic              errPolarity,
  input  logic              outEnable,
  input  logic [DATA_W-1:0] tsData,
  input  logic              tsClk,
  input  logic              tsSync,
  input  logic              tsValid,
  input  logic              tsErr,
  input  logic [ADC_W-1:0]  adcData,
  input  logic              adcClk,
  output logic [DATA_W-1:0] outData,
  output logic              outClk,
  output logic              outSync,
  output logic              outValid,
  output logic              outErr,
  output logic [PIN_N-1:0]  outOe
);

  routeStrobes_t strb;
  logic          unusedAdcHigh;

  assign unusedAdcHigh = ^adcData[ADC_W-1:DATA_W];

  ts_out_bypass_ctrl u_ctrl (
    .modeSel     (modeSel),
    .errPolarity (errPolarity),
    .outEnable   (outEnable),
    .strb        (strb)
  );

  ts_out_bypass_path #(.DATA_W(DATA_W)) u_path (
    .strb     (strb),
    .tsData   (tsData),
    .tsClk    (tsClk),
    .tsSync   (tsSync),
    .tsValid  (tsValid),
    .tsErr    (tsErr),
    .adcLow   (adcData[DATA_W-1:0]),
    .adcClk   (adcClk),
    .outData  (outData),
    .outClk   (outClk),
    .outSync  (outSync),
    .outValid (outValid),
    .outErr   (outErr),
    .outOe    (outOe)
  );

endmodule

// File: rtl/ts_out_bypass_chk.sv
module ts_out_bypass_chk #(
  parameter int DATA_W = 8,
  parameter int ADC_W  = 10,
  localparam int PIN_N = DATA_W + 4
) (
  input logic [1:0]        modeSel,
  input logic              errPolarity,
  input logic              outEnable,
  input logic [DATA_W-1:0] tsData,
  input logic              tsClk,
  input logic              tsSync,
  input logic              tsValid,
  input logic              tsErr,
  input logic [ADC_W-1:0]  adcData,
  input logic              adcClk,
  input logic [DATA_W-1:0] outData,
  input logic              outClk,
  input logic              outSync,
  input logic              outValid,
  input logic              outErr,
  input logic [PIN_N-1:0]  outOe
);

  always_comb begin
    if (modeSel != 2'b10) begin
      // R1
      normal_data_chk: assert (outData == tsData);
      // R2
      normal_side_chk: assert ({outClk, outSync, outValid, outErr} == {tsClk, tsSync, tsValid, tsErr});
    end else begin
      // R3
      bypass_data_chk: assert (outData == adcData[DATA_W-1:0]);
      // R4
      bypass_clk_chk: assert (outClk == adcClk);
      // R5
      bypass_frame_low_chk: assert (!outSync && !outValid);
      // R6
      bypass_err_level_chk: assert (outErr == errPolarity);
    end
    // R7
    oe_uniform_chk: assert (outEnable ? (&outOe) : (outOe == '0));
  end

endmodule

bind ts_out_bypass_mux ts_out_bypass_chk #(.DATA_W(DATA_W), .ADC_W(ADC_W)) u_chk (.*);

// File: tb/sim_ts_out_bypass_mux.sv
`timescale 1ns/1ps
module sim_ts_out_bypass_mux;

  logic       clk = 1'b0;
  logic [1:0] modeSel;
  logic       errPolarity, outEnable;
  logic [7:0] tsData;
  logic       tsClk, tsSync, tsValid, tsErr;
  logic [9:0] adcData;
  logic       adcClk;
  logic [7:0] outData;
  logic       outClk, outSync, outValid, outErr;
  logic [11:0] outOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ts_out_bypass_mux u0 (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%b pol=%b en=%b actual=%h expected=%h",
               tag, modeSel, errPolarity, outEnable, act, exp);
    end
  endtask

  function automatic logic [15:0] levels();
    return {3'b0, outData, outClk, outSync, outValid, outErr};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    modeSel = 2'b00; errPolarity = 0; outEnable = 0;
    tsData = 0; tsClk = 0; tsSync = 0; tsValid = 0; tsErr = 0;
    adcData = 0; adcClk = 0;
    @(negedge clk);
    // R7: initial, disabled port floats every pin
    check("R7 initial", {4'b0, outOe}, 16'h0000);

    for (int m = 0; m < 4; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int k = 0; k < 32; k++) begin
          logic       byp;
          logic [7:0] expData;
          logic       expClk, expSync, expValid, expErr;
          logic [15:0] lvlOn;
          @(posedge clk); #1;
          modeSel     = 2'(m);
          errPolarity = 1'(pol);
          outEnable   = 1'b1;
          tsData      = 8'((k * 29 + m * 7 + 3) & 255);
          adcData     = 10'((k * 53 + pol * 341 + m * 128) & 1023);
          {tsClk, tsSync, tsValid, tsErr} = 4'(k);
          adcClk      = 1'(k >> 4);
          byp      = (m == 2);
          expData  = byp ? adcData[7:0] : tsData;
          expClk   = byp ? adcClk : tsClk;
          expSync  = byp ? 1'b0 : tsSync;
          expValid = byp ? 1'b0 : tsValid;
          expErr   = byp ? 1'(pol) : tsErr;
          @(negedge clk);
          if (byp) begin
            check("R3 data", {8'b0, outData}, {8'b0, expData});
            check("R4 clk", {15'b0, outClk}, {15'b0, expClk});
            check("R5 sync/valid", {14'b0, outSync, outValid}, 16'h0);
            check("R6 err", {15'b0, outErr}, {15'b0, expErr});
          end else begin
            check("R1 data", {8'b0, outData}, {8'b0, expData});
            check("R2 sideband", {12'b0, outClk, outSync, outValid, outErr},
                  {12'b0, expClk, expSync, expValid, expErr});
          end
          check("R7 oe on", {4'b0, outOe}, 16'h0FFF);
          lvlOn = levels();
          outEnable = 1'b0;
          #1;
          check("R7 oe off", {4'b0, outOe}, 16'h0000);
          check("R8 levels", levels(), lvlOn);
          // R3: upper converter bits must not reach any pin
          adcData[9:8] = ~adcData[9:8];
          #1;
          check("R3 upper bits", levels(), lvlOn);
          if (byp) begin
            // R6: decoder error ignored in bypass; R5 framing ignored
            tsErr = ~tsErr; tsSync = ~tsSync; tsValid = ~tsValid;
            #1;
            check("R6 tsErr ignored", levels(), lvlOn);
          end else begin
            // R2: polarity has no effect outside bypass
            errPolarity = ~errPolarity;
            #1;
            check("R2 polarity ignored", levels(), lvlOn);
          end
        end
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule